// File: doc/BRIEF.md
# Row-Shared PI Flux Servo

This block closes a digital proportional/integral flux loop for one readout column whose detector rows are visited one at a time. A single arithmetic datapath serves every row. Each row keeps its own lock point, output offset, proportional gain, integral gain and integrator in small register arrays. A row's samples arrive as a stream. Each beat carries the row number and the ADC value, and the final beat of a row window is flagged.

For each window the block accumulates `lock - sample` over the beats and saturates the total to a 16-bit signed error. It then updates that row's integrator and emits one result beat. The result carries the row, the error and a 14-bit feedback word for the DAC. A sweep mode replaces the feedback word with a ramp so that response curves can be traced. Sweep mode also freezes every integrator. The ramp advances once per frame, meaning once per completed window of the highest-numbered row.

The result port is a one-entry valid/ready output. The sample input is valid/ready. `smp_ready` is low exactly while a result is waiting and `res_ready` is low. A beat is taken on a rising edge where `smp_valid` and `smp_ready` are both high. A result stays valid and unchanged until it is taken on an edge with `res_ready` high. A window may close on the same edge that drains the previous result. Coefficients are loaded through a plain write strobe.

Top module: `rowpi_servo`

## Requirements
- R1: After reset `res_valid` is 0 and `smp_ready` is 1. All integrators are 0, and so are all coefficients and the sweep ramp.
- R2: The row index is taken from the first beat of a window, and the `smp_row` field of later beats is ignored. The window error is the sum over its beats of (lock point of that row − sample), with samples and lock points signed 14-bit.
- R3: The error is saturated to the signed 16-bit range [−32768, 32767] rather than wrapped.
- R4: In servo mode the P term is floor(kp·err / 16) and the I step is floor(ki·err / 16), with both gains unsigned 8-bit. The feedback word is the row's DAC offset plus the updated integrator plus the P term, clamped to [0, 16383]. Equal kp and ki are allowed.
- R5: Each row's integrator is independent and persists across windows. Its update is clamped to the signed 20-bit range [−524288, 524287].
- R6: `res_valid` rises on the edge that accepts a window's last beat, with `res_row`, `res_err` and `res_fb` for that window. It falls after the result is taken unless a new window closes on that edge.
- R7: While `res_valid` is 1 and `res_ready` is 0, `smp_ready` is 0 and the result fields hold steady.
- R8: With `sweep_en` high when a window closes, `res_fb` equals the current ramp value. The row's integrator is left unchanged, and the error is still reported.
- R9: The ramp is 0 whenever `sweep_en` is low. In sweep mode it advances by SWEEP_STEP (modulo 16384) after each window of row ROWS−1 closes.
- R10: A coefficient write (`cfg_we`) replaces all four coefficients of `cfg_row`. The new values apply to beats accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Servo clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_row | input | 3 | Row whose coefficients are written |
| cfg_lock | input | 14 | Lock point, signed |
| cfg_dac_off | input | 14 | Feedback offset, unsigned |
| cfg_kp | input | 8 | Proportional gain, unsigned |
| cfg_ki | input | 8 | Integral gain, unsigned |
| sweep_en | input | 1 | Sweep (ramp) mode select |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Sample beat accepted when high |
| smp_data | input | 14 | ADC sample, signed |
| smp_row | input | 3 | Row number, used on the first beat of a window |
| smp_last | input | 1 | Marks the final beat of a window |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result consumer ready |
| res_row | output | 3 | Row of the result |
| res_err | output | 16 | Saturated window error, signed |
| res_fb | output | 14 | Feedback DAC word |

## Verification
The assertions rely on several conditions holding at the inputs:
- No window is longer than MAX_SAMP beats, so the accumulator cannot wrap.
- `smp_row` on a first beat is below ROWS.
- Coefficients of a row are not rewritten while that row's window is open.
- `sweep_en` changes only between windows.

The bench keeps to these conditions by construction. Window lengths are drawn from 1 to 8 and rows from 0 to 7. Configuration writes and mode changes are issued only after a result has been drained. Random gains, lock points, samples and hold-off lengths are mixed with directed windows that drive the error, the integrator and the feedback clamp to both rails, and that walk the ramp through a wrap.

// File: rtl/rowpi_pkg.sv
package rowpi_pkg;
  // Defaults shared by the servo and its bench
  localparam int ROWS_DEF     = 8;
  localparam int ADC_W_DEF    = 14;
  localparam int DAC_W_DEF    = 14;
  localparam int ERR_W_DEF    = 16;
  localparam int GAIN_W_DEF   = 8;
  localparam int GSH_DEF      = 4;
  localparam int INT_W_DEF    = 20;
  localparam int MAX_SAMP_DEF = 16;
endpackage

// File: rtl/rowpi_coef_bank.sv
module rowpi_coef_bank #(
  parameter int ROWS   = 8,
  parameter int RW     = 3,
  parameter int ADC_W  = 14,
  parameter int DAC_W  = 14,
  parameter int GAIN_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [RW-1:0]            wr_row,
  input  logic signed [ADC_W-1:0]  wr_lock,
  input  logic [DAC_W-1:0]         wr_off,
  input  logic [GAIN_W-1:0]        wr_kp,
  input  logic [GAIN_W-1:0]        wr_ki,
  input  logic [RW-1:0]            rd_row,
  output logic signed [ADC_W-1:0]  rd_lock,
  output logic [DAC_W-1:0]         rd_off,
  output logic [GAIN_W-1:0]        rd_kp,
  output logic [GAIN_W-1:0]        rd_ki
);
  logic signed [ADC_W-1:0] lock_q [ROWS];
  logic [DAC_W-1:0]        off_q  [ROWS];
  logic [GAIN_W-1:0]       kp_q   [ROWS];
  logic [GAIN_W-1:0]       ki_q   [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_q[g] <= '0;
        off_q[g]  <= '0;
        kp_q[g]   <= '0;
        ki_q[g]   <= '0;
      end else if (wr_en && wr_row == RW'(g)) begin
        lock_q[g] <= wr_lock;
        off_q[g]  <= wr_off;
        kp_q[g]   <= wr_kp;
        ki_q[g]   <= wr_ki;
      end
    end
  end

  assign rd_lock = lock_q[rd_row];
  assign rd_off  = off_q[rd_row];
  assign rd_kp   = kp_q[rd_row];
  assign rd_ki   = ki_q[rd_row];
endmodule

// File: rtl/rowpi_err_acc.sv
module rowpi_err_acc #(
  parameter int RW    = 3,
  parameter int ADC_W = 14,
  parameter int ACC_W = 22
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic                     last,
  input  logic [RW-1:0]            smp_row,
  input  logic signed [ADC_W-1:0]  smp,
  input  logic signed [ADC_W-1:0]  lock,
  output logic [RW-1:0]            row_now,
  output logic signed [ACC_W-1:0]  acc_sum
);
  logic                     in_win;
  logic [RW-1:0]            row_q;
  logic signed [ACC_W-1:0]  acc;

  // Row is captured on the opening beat; later row fields are ignored
  assign row_now = in_win ? row_q : smp_row;
  assign acc_sum = (in_win ? acc : ACC_W'(0)) + ACC_W'(lock) - ACC_W'(smp);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_win <= 1'b0;
      row_q  <= '0;
      acc    <= '0;
    end else if (beat) begin
      if (last) begin
        in_win <= 1'b0;
        acc    <= '0;
      end else begin
        in_win <= 1'b1;
        row_q  <= row_now;
        acc    <= acc_sum;
      end
    end
  end

  // R2
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_win |-> acc == '0);
endmodule

// File: rtl/rowpi_sweep.sv
module rowpi_sweep #(
  parameter int ROWS  = 8,
  parameter int RW    = 3,
  parameter int DAC_W = 14,
  parameter int STEP  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_en,
  input  logic              commit,
  input  logic [RW-1:0]     row,
  output logic [DAC_W-1:0]  ramp
);
  logic frame_end;
  assign frame_end = commit && row == RW'(ROWS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !sweep_en) ramp <= '0;
    else if (frame_end)      ramp <= ramp + DAC_W'(STEP);
  end

  // R9
  ramp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_en && !frame_end |=> !sweep_en || $stable(ramp));
endmodule

// File: rtl/rowpi_pi_core.sv
module rowpi_pi_core #(
  parameter int ROWS   = 8,
  parameter int RW     = 3,
  parameter int ACC_W  = 22,
  parameter int ERR_W  = 16,
  parameter int DAC_W  = 14,
  parameter int GAIN_W = 8,
  parameter int GSH    = 4,
  parameter int INT_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [RW-1:0]            row,
  input  logic signed [ACC_W-1:0]  acc_sum,
  input  logic [DAC_W-1:0]         dac_off,
  input  logic [GAIN_W-1:0]        kp,
  input  logic [GAIN_W-1:0]        ki,
  input  logic                     sweep_en,
  input  logic [DAC_W-1:0]         ramp,
  input  logic                     res_ready,
  output logic                     res_valid,
  output logic [RW-1:0]            res_row,
  output logic signed [ERR_W-1:0]  res_err,
  output logic [DAC_W-1:0]         res_fb
);
  localparam int PW = GAIN_W + ERR_W + 1;
  localparam int SW = (PW > INT_W ? PW : INT_W) + 3;
  localparam logic signed [ACC_W-1:0] A_HI = {{(ACC_W-ERR_W+1){1'b0}}, {(ERR_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] A_LO = {{(ACC_W-ERR_W+1){1'b1}}, {(ERR_W-1){1'b0}}};
  localparam logic signed [SW-1:0]    I_HI = {{(SW-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic signed [SW-1:0]    I_LO = {{(SW-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}};
  localparam logic signed [SW-1:0]    F_HI = {{(SW-DAC_W){1'b0}}, {DAC_W{1'b1}}};

  logic signed [INT_W-1:0] integ [ROWS];
  logic signed [ERR_W-1:0] err;
  logic signed [PW-1:0]    pterm, iterm;
  logic signed [SW-1:0]    isum, fsum;
  logic signed [INT_W-1:0] i_new;
  logic [DAC_W-1:0]        fb;

  always_comb begin
    if (acc_sum > A_HI)      err = A_HI[ERR_W-1:0];
    else if (acc_sum < A_LO) err = A_LO[ERR_W-1:0];
    else                     err = acc_sum[ERR_W-1:0];
    pterm = ($signed({1'b0, kp}) * err) >>> GSH;
    iterm = ($signed({1'b0, ki}) * err) >>> GSH;
    isum  = integ[row] + iterm;
    if (sweep_en)         i_new = integ[row];
    else if (isum > I_HI) i_new = I_HI[INT_W-1:0];
    else if (isum < I_LO) i_new = I_LO[INT_W-1:0];
    else                  i_new = isum[INT_W-1:0];
    fsum = $signed({1'b0, dac_off}) + i_new + pterm;
    if (sweep_en)            fb = ramp;
    else if (fsum < 0)       fb = '0;
    else if (fsum > F_HI)    fb = F_HI[DAC_W-1:0];
    else                     fb = fsum[DAC_W-1:0];
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_int
    always_ff @(posedge clk) begin
      if (!rst_n)                          integ[g] <= '0;
      else if (commit && row == RW'(g))    integ[g] <= i_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_row   <= '0;
      res_err   <= '0;
      res_fb    <= '0;
    end else if (commit) begin
      res_valid <= 1'b1;
      res_row   <= row;
      res_err   <= err;
      res_fb    <= fb;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_fb) && $stable(res_err) && $stable(res_row));
endmodule

// File: rtl/rowpi_servo.sv
module rowpi_servo
  import rowpi_pkg::*;
#(
  parameter int ROWS       = ROWS_DEF,
  parameter int ADC_W      = ADC_W_DEF,
  parameter int DAC_W      = DAC_W_DEF,
  parameter int ERR_W      = ERR_W_DEF,
  parameter int GAIN_W     = GAIN_W_DEF,
  parameter int GSH        = GSH_DEF,
  parameter int INT_W      = INT_W_DEF,
  parameter int MAX_SAMP   = MAX_SAMP_DEF,
  parameter int SWEEP_STEP = 1,
  localparam int RW        = $clog2(ROWS),
  localparam int ACC_W     = ADC_W + 2 + $clog2(MAX_SAMP)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [RW-1:0]            cfg_row,
  input  logic signed [ADC_W-1:0]  cfg_lock,
  input  logic [DAC_W-1:0]         cfg_dac_off,
  input  logic [GAIN_W-1:0]        cfg_kp,
  input  logic [GAIN_W-1:0]        cfg_ki,
  input  logic                     sweep_en,
  input  logic                     smp_valid,
  output logic                     smp_ready,
  input  logic signed [ADC_W-1:0]  smp_data,
  input  logic [RW-1:0]            smp_row,
  input  logic                     smp_last,
  output logic                     res_valid,
  input  logic                     res_ready,
  output logic [RW-1:0]            res_row,
  output logic signed [ERR_W-1:0]  res_err,
  output logic [DAC_W-1:0]         res_fb
);
  logic                     beat, commit;
  logic [RW-1:0]            row_now;
  logic signed [ADC_W-1:0]  lock;
  logic [DAC_W-1:0]         dac_off, ramp;
  logic [GAIN_W-1:0]        kp, ki;
  logic signed [ACC_W-1:0]  acc_sum;

  // One-entry result slot: stall input while a result waits
  assign smp_ready = !res_valid || res_ready;
  assign beat      = smp_valid && smp_ready;
  assign commit    = beat && smp_last;

  rowpi_coef_bank #(.ROWS(ROWS), .RW(RW), .ADC_W(ADC_W), .DAC_W(DAC_W), .GAIN_W(GAIN_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_row(cfg_row), .wr_lock(cfg_lock),
    .wr_off(cfg_dac_off), .wr_kp(cfg_kp), .wr_ki(cfg_ki), .rd_row(row_now),
    .rd_lock(lock), .rd_off(dac_off), .rd_kp(kp), .rd_ki(ki));

  rowpi_err_acc #(.RW(RW), .ADC_W(ADC_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(smp_last), .smp_row(smp_row),
    .smp(smp_data), .lock(lock), .row_now(row_now), .acc_sum(acc_sum));

  rowpi_sweep #(.ROWS(ROWS), .RW(RW), .DAC_W(DAC_W), .STEP(SWEEP_STEP)) u_sweep (
    .clk(clk), .rst_n(rst_n), .sweep_en(sweep_en), .commit(commit), .row(row_now), .ramp(ramp));

  rowpi_pi_core #(.ROWS(ROWS), .RW(RW), .ACC_W(ACC_W), .ERR_W(ERR_W), .DAC_W(DAC_W),
                  .GAIN_W(GAIN_W), .GSH(GSH), .INT_W(INT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .commit(commit), .row(row_now), .acc_sum(acc_sum),
    .dac_off(dac_off), .kp(kp), .ki(ki), .sweep_en(sweep_en), .ramp(ramp),
    .res_ready(res_ready), .res_valid(res_valid), .res_row(res_row),
    .res_err(res_err), .res_fb(res_fb));

  // R8
  sweep_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit && sweep_en |=> res_fb == $past(ramp));

  // R7
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !res_valid || res_ready);

  // R6
  res_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> res_valid);
endmodule

// File: tb/sim_rowpi_servo.sv
`timescale 1ns/1ps
module sim_rowpi_servo;
  localparam int STEP = 4096;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_row = '0;
  logic signed [13:0] cfg_lock = '0;
  logic [13:0] cfg_dac_off = '0;
  logic [7:0] cfg_kp = '0, cfg_ki = '0;
  logic sweep_en = 1'b0, smp_valid = 1'b0, smp_last = 1'b0, res_ready = 1'b0;
  logic signed [13:0] smp_data = '0;
  logic [2:0] smp_row = '0;
  logic smp_ready, res_valid;
  logic [2:0] res_row;
  logic signed [15:0] res_err;
  logic [13:0] res_fb;

  int checks = 0, errors = 0;
  bit done = 0;
  longint m_lock [8], m_off [8], m_kp [8], m_ki [8], m_int [8];
  longint m_ramp = 0;

  always #2 clk = ~clk;

  rowpi_servo #(.SWEEP_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_lock(cfg_lock),
    .cfg_dac_off(cfg_dac_off), .cfg_kp(cfg_kp), .cfg_ki(cfg_ki), .sweep_en(sweep_en),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_data(smp_data), .smp_row(smp_row),
    .smp_last(smp_last), .res_valid(res_valid), .res_ready(res_ready), .res_row(res_row),
    .res_err(res_err), .res_fb(res_fb));

  function automatic longint clampl(input longint v, input longint lo, input longint hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R10: write all four coefficients of one row
  task automatic cfg(input int row, input longint lock, input longint off, input longint kp, input longint ki);
    @(negedge clk);
    cfg_we = 1; cfg_row = 3'(row); cfg_lock = 14'(lock); cfg_dac_off = 14'(off);
    cfg_kp = 8'(kp); cfg_ki = 8'(ki);
    @(negedge clk);
    cfg_we = 0;
    m_lock[row] = lock; m_off[row] = off; m_kp[row] = kp; m_ki[row] = ki;
  endtask

  task automatic window(input int row, input int n, input int hold, input bit fixd, input longint fixv);
    longint acc = 0, e, p, iv, fb, smp;
    logic signed [15:0] cap_err;
    logic [13:0] cap_fb;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      smp = fixd ? fixv : longint'($urandom % 16384) - 8192;
      acc += m_lock[row] - smp;
      smp_valid = 1; smp_data = 14'(smp); smp_last = (b == n - 1);
      smp_row = (b == 0) ? 3'(row) : 3'($urandom % 8);
      @(posedge clk);
    end
    @(negedge clk);
    smp_valid = 0; smp_last = 0;
    e = clampl(acc, -32768, 32767);
    if (sweep_en) begin
      fb = m_ramp;
      if (row == 7) m_ramp = (m_ramp + STEP) % 16384;
    end else begin
      p  = (m_kp[row] * e) >>> 4;
      iv = clampl(m_int[row] + ((m_ki[row] * e) >>> 4), -524288, 524287);
      m_int[row] = iv;
      fb = clampl(m_off[row] + iv + p, 0, 16383);
    end
    // R6: result present the cycle after the last beat
    chk(res_valid == 1, "R6 res_valid", longint'(res_valid), 1);
    chk(res_row == 3'(row), "R2 res_row", longint'(res_row), row);
    // R2 / R3: saturated accumulated error
    chk(longint'(res_err) == e, "R2/R3 res_err", longint'(res_err), e);
    // R4 / R5 / R8: feedback word
    chk(longint'(res_fb) == fb, "R4/R8 res_fb", longint'(res_fb), fb);
    cap_err = res_err; cap_fb = res_fb;
    for (int h = 0; h < hold; h++) begin
      chk(smp_ready == 0, "R7 smp_ready low", longint'(smp_ready), 0);
      @(negedge clk);
      chk(res_valid && res_fb == cap_fb && res_err == cap_err, "R7 hold",
          longint'(res_fb), longint'(cap_fb));
    end
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk(res_valid == 0, "R6 res_valid drop", longint'(res_valid), 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < 8; r++) begin
      m_lock[r] = 0; m_off[r] = 0; m_kp[r] = 0; m_ki[r] = 0; m_int[r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 0, "R1 res_valid", longint'(res_valid), 0);
    chk(smp_ready == 1, "R1 smp_ready", longint'(smp_ready), 1);
    // R1: zero coefficients and integrator give zero feedback
    window(4, 3, 0, 1, 0);

    // Random coefficients, kp == ki on row 2 (R4)
    for (int r = 0; r < 8; r++)
      cfg(r, longint'($urandom % 4096) - 2048, 4096 + longint'($urandom % 8192),
          $urandom % 32, $urandom % 32);
    cfg(2, 100, 8000, 16, 16);
    for (int k = 0; k < 40; k++)
      window($urandom % 8, 1 + $urandom % 8, $urandom % 4, 0, 0);

    // R3: error saturates both ways
    cfg(3, 8191, 100, 0, 0);
    window(3, 8, 1, 1, -8192);
    cfg(3, -8192, 100, 0, 0);
    window(3, 8, 0, 1, 8191);

    // R5 / R4: integrator and feedback clamp to the rails
    cfg(5, 8191, 0, 0, 255);
    window(5, 8, 0, 1, -8192);
    window(5, 8, 0, 1, -8192);
    cfg(5, -8192, 0, 0, 255);
    window(5, 8, 0, 1, 8191);
    window(5, 8, 0, 1, 8191);

    // R10: new lock point applies to the next window
    cfg(6, 500, 8192, 4, 2);
    window(6, 2, 0, 1, 0);

    // R8 / R9: sweep ramp per frame, wrap, frozen integrators
    @(negedge clk); sweep_en = 1; m_ramp = 0;
    for (int k = 0; k < 5; k++) window(7, 2, 0, 0, 0);
    window(1, 3, 2, 0, 0);
    @(negedge clk); sweep_en = 0; m_ramp = 0;
    window(1, 3, 0, 0, 0);
    @(negedge clk); sweep_en = 1;
    window(7, 1, 0, 0, 0);
    @(negedge clk); sweep_en = 0; m_ramp = 0;
    window(0, 4, 0, 0, 0);

    report();
  end
endmodule